// File: doc/BRIEF.md
# Two-Channel Word DMA Engine

The block moves 16-bit words between two locations without CPU help. Two identical channels each hold a 20-bit source pointer, a 20-bit destination pointer, a 16-bit word counter and a control word. A channel that is armed and has work left asks an arbiter for service. The winner takes a simple request/grant bus and reads one word from the source. It then writes that word to the destination and updates its pointers and its counter. After each word the channel competes again.

Each pointer can move up or down by one word (two bytes) or stay fixed. The source and the destination can each sit in memory space or in I/O space. A channel can start words freely or wait for its request line, which may belong to the source device or to the destination device. After a paced word the line is ignored for a short window, so the device has time to drop it. A channel can instead take one word per pulse of a shared timer line. A non-maskable interrupt freezes the engine until an interrupt-return pulse arrives. Each channel raises its interrupt line when its counter runs out.

Software reaches the registers through a flat register port. Address bit 3 selects the channel and bits 2:0 select the register.

Top module: `dual_dma_engine`

## Requirements
- R1: After reset every register reads 0, both interrupt lines are low and no bus request is made. Register index 0/1 holds the source pointer low 16 bits / high 4 bits, 2/3 the destination pointer, 4 the counter, and 5 the control word.
- R2: A word move asserts bus_req_o and waits for bus_gnt_i. It then reads from the source (bus_stb_o with bus_we_o low, until bus_ack_i). Next it writes the read data to the destination (bus_stb_o with bus_we_o high, until bus_ack_i). bus_stb_o is never high without grant.
- R3: The counter drops by exactly 1 per moved word. When it reaches 0 the control arm bit (bit 0) clears and the channel stops. A channel armed with a counter of 0 never requests the bus.
- R4: Each pointer field (source bits 7:6, destination bits 9:8) means 01 = add 2, 10 = subtract 2, and 00 or 11 = hold. Stepping wraps modulo 2^20.
- R5: Control bit 10 places the source, and bit 11 the destination, in I/O space. bus_io_o is high during an access to I/O space.
- R6: With pacing field bits 5:4 = 00 an armed channel moves words back to back until its counter is 0.
- R7: With pacing 01 (source-paced) a word starts only while the channel's request line is high. The line is not sampled for 3 cycles after the word completes.
- R8: With pacing 10 (destination-paced) a word starts only while the request line is high. The line is not sampled for 2 cycles after the word completes.
- R9: With control bit 2 set, the request line is ignored and each pulse on the timer input grants exactly one word.
- R10: When both channels request at once and their priority bits (bit 3) differ, the channel with the bit set wins.
- R11: When both request with equal priority bits, the channel not served most recently wins. After reset, channel 0 is served first.
- R12: A pulse on nmi_i stops any new bus request until a pulse on iret_i. If both arrive together, the halt wins.
- R13: A channel's interrupt line rises when its counter reaches 0 while its interrupt-enable bit (bit 1) is set. It stays high until that channel's control word is written. With the enable bit clear the line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drq_i | input | 2 | Per-channel pacing request lines |
| tmr_req_i | input | 1 | Timer pulse, one word per pulse on timer-triggered channels |
| nmi_i | input | 1 | Non-maskable interrupt pulse, halts the engine |
| iret_i | input | 1 | Interrupt-return pulse, releases the halt |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Bit 3 channel, bits 2:0 register index |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus ownership grant |
| bus_stb_o | output | 1 | Access strobe, held until acknowledge |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_io_o | output | 1 | 1 = I/O space, 0 = memory space |
| bus_addr_o | output | 20 | Byte address of the access |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access acknowledge |
| irq_o | output | 2 | Per-channel terminal-count interrupt |

## Verification
The bench builds the engine with its defaults: 20-bit pointers, 16-bit data and counters, a source window of 3 and a destination window of 2. With these widths a two-word downward move from address 2 crosses address 0 and lands on 0xFFFFE, so the wrap of the pointer arithmetic can be checked at the register port. With the default window lengths, a request line held high one cycle too long shows up as an extra word. Halting both channels while they are armed lets them request in the same cycle, which brings the priority and alternation orderings within reach.

// File: rtl/ddma_pkg.sv
// Shared types for the two-channel DMA engine: control word layout,
// pacing and pointer-step encodings, and the mover sequencer states.
package ddma_pkg;

    typedef enum logic [1:0] {
        PACE_FREE = 2'b00,
        PACE_SRC  = 2'b01,
        PACE_DST  = 2'b10,
        PACE_RSVD = 2'b11
    } pace_e;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_UP    = 2'b01,
        STEP_DOWN  = 2'b10,
        STEP_HOLD2 = 2'b11
    } step_e;

    // Control word, bit 0 at the bottom (arm) up to bit 11 (dst_io).
    typedef struct packed {
        logic  dst_io;
        logic  src_io;
        step_e dst_step;
        step_e src_step;
        pace_e pace;
        logic  prio;
        logic  tmr_sel;
        logic  ie;
        logic  arm;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [2:0] {
        MV_IDLE,
        MV_REQ,
        MV_RD,
        MV_WR,
        MV_DONE
    } mv_state_e;

endpackage

// File: rtl/ddma_chan.sv
// One DMA channel: pointer, counter and control registers, the pacing
// window, the timer pending flag and the terminal-count interrupt.
// Assumes the register port width is at least 16 bits and CNT_W <= DATA_W.
module ddma_chan
    import ddma_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 16,
    parameter int SRC_GUARD = 3,
    parameter int DST_GUARD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [2:0]        idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              drq_i,
    input  logic              tmr_i,
    input  logic              done_i,
    output logic              req_o,
    output ctrl_t             ctrl_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_o
);

    localparam int HI_W = ADDR_W - 16;
    localparam int GMAX = (SRC_GUARD > DST_GUARD) ? SRC_GUARD : DST_GUARD;
    localparam int GW   = (GMAX < 2) ? 1 : $clog2(GMAX + 1);

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [GW-1:0]     guard_q, guard_ld;
    logic              irq_q, tmr_pend_q, trig;

    // Pointer stepping by one 16-bit word, wrapping at the address width.
    function automatic logic [ADDR_W-1:0] stepped(input logic [ADDR_W-1:0] p,
                                                   input step_e s);
        case (s)
            STEP_UP:   return p + ADDR_W'(2);
            STEP_DOWN: return p - ADDR_W'(2);
            default:   return p;
        endcase
    endfunction

    // Length of the sampling blackout loaded after a paced word.
    always_comb begin
        guard_ld = '0;
        if (!ctrl_q.tmr_sel) begin
            if (ctrl_q.pace == PACE_SRC)      guard_ld = GW'(SRC_GUARD);
            else if (ctrl_q.pace == PACE_DST) guard_ld = GW'(DST_GUARD);
        end
    end

    // Trigger condition selected by the timer bit and the pacing field.
    always_comb begin
        if (ctrl_q.tmr_sel)                                      trig = tmr_pend_q;
        else if (ctrl_q.pace == PACE_SRC || ctrl_q.pace == PACE_DST) trig = drq_i;
        else                                                     trig = 1'b1;
    end

    assign req_o = ctrl_q.arm && (cnt_q != '0) && (guard_q == '0) && trig;

    // Register writes, per-word updates, window countdown and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            guard_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (wr_en_i) begin
                case (idx_i)
                    3'd0: src_q[15:0]       <= wr_data_i[15:0];
                    3'd1: src_q[ADDR_W-1:16] <= wr_data_i[HI_W-1:0];
                    3'd2: dst_q[15:0]       <= wr_data_i[15:0];
                    3'd3: dst_q[ADDR_W-1:16] <= wr_data_i[HI_W-1:0];
                    3'd4: cnt_q             <= wr_data_i[CNT_W-1:0];
                    3'd5: begin
                        ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
                        irq_q  <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (done_i) begin
                src_q   <= stepped(src_q, ctrl_q.src_step);
                dst_q   <= stepped(dst_q, ctrl_q.dst_step);
                cnt_q   <= cnt_q - CNT_W'(1);
                guard_q <= guard_ld;
                if (cnt_q == CNT_W'(1)) begin
                    ctrl_q.arm <= 1'b0;
                    if (ctrl_q.ie) irq_q <= 1'b1;
                end
            end else if (guard_q != '0) begin
                guard_q <= guard_q - GW'(1);
            end
        end
    end

    // Timer pulse latch: one pending word per pulse, dropped when not armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_pend_q <= 1'b0;
        end else if (!ctrl_q.arm || !ctrl_q.tmr_sel) begin
            tmr_pend_q <= 1'b0;
        end else if (tmr_i) begin
            tmr_pend_q <= 1'b1;
        end else if (done_i) begin
            tmr_pend_q <= 1'b0;
        end
    end

    // Register read mux for this channel.
    always_comb begin
        case (idx_i)
            3'd0:    rd_data_o = DATA_W'(src_q[15:0]);
            3'd1:    rd_data_o = DATA_W'(src_q[ADDR_W-1:16]);
            3'd2:    rd_data_o = DATA_W'(dst_q[15:0]);
            3'd3:    rd_data_o = DATA_W'(dst_q[ADDR_W-1:16]);
            3'd4:    rd_data_o = DATA_W'(cnt_q);
            3'd5:    rd_data_o = DATA_W'(ctrl_q);
            default: rd_data_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign src_o  = src_q;
    assign dst_o  = dst_q;
    assign cnt_o  = cnt_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/ddma_arb.sv
// Two-way arbiter: the priority bit decides when the two bits differ;
// otherwise the channel not served last wins. Assumes take_i only when valid_o.
module ddma_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_i,
    input  logic [1:0] prio_i,
    input  logic       take_i,
    output logic       valid_o,
    output logic       ch_o
);

    logic last_q;

    // Winner selection for the current cycle.
    always_comb begin
        valid_o = |req_i;
        if (req_i == 2'b11) begin
            ch_o = (prio_i[0] != prio_i[1]) ? prio_i[1] : ~last_q;
        end else begin
            ch_o = req_i[1];
        end
    end

    // Remember the last channel served; reset makes channel 0 first.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= 1'b1;
        else if (take_i) last_q <= ch_o;
    end

endmodule

// File: rtl/ddma_mover.sv
// Bus sequencer for one word: request ownership, read source, write
// destination, then report completion. Assumes grant stays high while requested.
module ddma_mover
    import ddma_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic              src_io_i,
    input  logic              dst_io_i,
    output logic              idle_o,
    output logic              done_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              bus_stb_o,
    output logic              bus_we_o,
    output logic              bus_io_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_ack_i
);

    mv_state_e         state_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic              src_io_q, dst_io_q;
    logic [DATA_W-1:0] data_q;

    // Sequencer state and per-word latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= MV_IDLE;
            src_q    <= '0;
            dst_q    <= '0;
            src_io_q <= 1'b0;
            dst_io_q <= 1'b0;
            data_q   <= '0;
        end else begin
            case (state_q)
                MV_IDLE: if (start_i) begin
                    src_q    <= src_i;
                    dst_q    <= dst_i;
                    src_io_q <= src_io_i;
                    dst_io_q <= dst_io_i;
                    state_q  <= MV_REQ;
                end
                MV_REQ:  if (bus_gnt_i) state_q <= MV_RD;
                MV_RD:   if (bus_ack_i) begin
                    data_q  <= bus_rdata_i;
                    state_q <= MV_WR;
                end
                MV_WR:   if (bus_ack_i) state_q <= MV_DONE;
                default: state_q <= MV_IDLE;
            endcase
        end
    end

    // Bus outputs decoded from the state.
    always_comb begin
        idle_o      = (state_q == MV_IDLE);
        done_o      = (state_q == MV_DONE);
        bus_req_o   = (state_q == MV_REQ) || (state_q == MV_RD) || (state_q == MV_WR);
        bus_stb_o   = (state_q == MV_RD) || (state_q == MV_WR);
        bus_we_o    = (state_q == MV_WR);
        bus_io_o    = (state_q == MV_WR) ? dst_io_q : src_io_q;
        bus_addr_o  = (state_q == MV_WR) ? dst_q : src_q;
        bus_wdata_o = data_q;
    end

endmodule

// File: rtl/dual_dma_engine.sv
// Top of the two-channel DMA engine: two channel register sets, the
// arbiter, the word mover and the halt flag. One word is in flight at a time.
// Assumes pulses on nmi_i/iret_i/tmr_req_i are synchronous to clk.
module dual_dma_engine
    import ddma_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 16,
    parameter int SRC_GUARD = 3,
    parameter int DST_GUARD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        drq_i,
    input  logic              tmr_req_i,
    input  logic              nmi_i,
    input  logic              iret_i,
    input  logic              reg_we_i,
    input  logic [3:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              bus_stb_o,
    output logic              bus_we_o,
    output logic              bus_io_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_ack_i,
    output logic [1:0]        irq_o
);

    localparam int NCH = 2;

    ctrl_t [NCH-1:0]             ctrl_v;
    logic  [NCH-1:0][ADDR_W-1:0] src_v, dst_v;
    logic  [NCH-1:0][CNT_W-1:0]  cnt_v;
    logic  [NCH-1:0][DATA_W-1:0] rd_v;
    logic  [NCH-1:0]             chan_req, req_eff, prio_v;
    logic                        halt_q, sel_q, pick_valid, pick_ch;
    logic                        mover_idle, done_w, start_go;

    // Halt flag: set by the non-maskable interrupt, cleared by interrupt return.
    always_ff @(posedge clk) begin
        if (!rst_n)      halt_q <= 1'b0;
        else if (nmi_i)  halt_q <= 1'b1;
        else if (iret_i) halt_q <= 1'b0;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ddma_chan #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
            .SRC_GUARD(SRC_GUARD), .DST_GUARD(DST_GUARD)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (reg_we_i && (reg_addr_i[3] == 1'(c))),
            .idx_i    (reg_addr_i[2:0]),
            .wr_data_i(reg_wdata_i),
            .rd_data_o(rd_v[c]),
            .drq_i    (drq_i[c]),
            .tmr_i    (tmr_req_i),
            .done_i   (done_w && (sel_q == 1'(c))),
            .req_o    (chan_req[c]),
            .ctrl_o   (ctrl_v[c]),
            .src_o    (src_v[c]),
            .dst_o    (dst_v[c]),
            .cnt_o    (cnt_v[c]),
            .irq_o    (irq_o[c])
        );
        assign prio_v[c] = ctrl_v[c].prio;
    end

    assign req_eff     = chan_req & {NCH{~halt_q}};
    assign start_go    = mover_idle && pick_valid;
    assign reg_rdata_o = rd_v[reg_addr_i[3]];

    ddma_arb u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_eff),
        .prio_i (prio_v),
        .take_i (start_go),
        .valid_o(pick_valid),
        .ch_o   (pick_ch)
    );

    // Channel that owns the word in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= 1'b0;
        else if (start_go) sel_q <= pick_ch;
    end

    ddma_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_go),
        .src_i      (src_v[pick_ch]),
        .dst_i      (dst_v[pick_ch]),
        .src_io_i   (ctrl_v[pick_ch].src_io),
        .dst_io_i   (ctrl_v[pick_ch].dst_io),
        .idle_o     (mover_idle),
        .done_o     (done_w),
        .bus_req_o  (bus_req_o),
        .bus_gnt_i  (bus_gnt_i),
        .bus_stb_o  (bus_stb_o),
        .bus_we_o   (bus_we_o),
        .bus_io_o   (bus_io_o),
        .bus_addr_o (bus_addr_o),
        .bus_wdata_o(bus_wdata_o),
        .bus_rdata_i(bus_rdata_i),
        .bus_ack_i  (bus_ack_i)
    );

endmodule

// File: rtl/ddma_checker.sv
// Property checker for dual_dma_engine, attached by bind below.
// Tracks cycles since each channel's last completed word to check windows.
module ddma_checker
    import ddma_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SRC_GUARD = 3,
    parameter int DST_GUARD = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_req,
    input logic                       bus_gnt,
    input logic                       bus_stb,
    input logic                       halt,
    input logic                       start,
    input logic                       pick,
    input logic                       done,
    input logic                       sel,
    input ctrl_t [1:0]                ctrl,
    input logic [1:0][CNT_W-1:0]      cnt,
    input logic [1:0]                 irq
);

    assert_stb_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |-> bus_gnt);

    assert_halt_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !bus_req |=> !bus_req);

    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic [7:0] gap_q;

        // Cycles since this channel last completed a word, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n)                        gap_q <= 8'hFF;
            else if (done && sel == 1'(c))     gap_q <= 8'd0;
            else if (gap_q != 8'hFF)           gap_q <= gap_q + 8'd1;
        end

        assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            done && sel == 1'(c) |=> cnt[c] == $past(cnt[c]) - CNT_W'(1));

        assert_irq_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> cnt[c] == '0 && ctrl[c].ie);

        assert_src_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
            start && pick == 1'(c) && ctrl[c].pace == PACE_SRC && !ctrl[c].tmr_sel
            |-> gap_q >= 8'(SRC_GUARD));

        assert_dst_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
            start && pick == 1'(c) && ctrl[c].pace == PACE_DST && !ctrl[c].tmr_sel
            |-> gap_q >= 8'(DST_GUARD));
    end

endmodule

bind dual_dma_engine ddma_checker #(
    .CNT_W(CNT_W), .SRC_GUARD(SRC_GUARD), .DST_GUARD(DST_GUARD)
) u_ddma_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_req(bus_req_o),
    .bus_gnt(bus_gnt_i),
    .bus_stb(bus_stb_o),
    .halt   (halt_q),
    .start  (start_go),
    .pick   (pick_ch),
    .done   (done_w),
    .sel    (sel_q),
    .ctrl   (ctrl_v),
    .cnt    (cnt_v),
    .irq    (irq_o)
);

// File: tb/test_dual_dma_engine.sv
module test_dual_dma_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  drq = 2'b00;
    logic        tmr = 1'b0, nmi = 1'b0, iret = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_req_o, bus_stb_o, bus_we_o, bus_io_o;
    logic        bus_gnt = 1'b0, bus_ack = 1'b0;
    logic [19:0] bus_addr_o;
    logic [15:0] bus_wdata_o, bus_rdata;
    logic [1:0]  irq_o;

    int n_chk = 0, n_fail = 0;
    int req_cycles = 0, rd_total = 0;
    logic [19:0] rd_log [64];
    logic [15:0] mem_m  [512];
    logic [15:0] mem_io [512];

    dual_dma_engine i_dual_dma_engine (
        .clk(clk), .rst_n(rst_n), .drq_i(drq), .tmr_req_i(tmr), .nmi_i(nmi),
        .iret_i(iret), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt), .bus_stb_o(bus_stb_o),
        .bus_we_o(bus_we_o), .bus_io_o(bus_io_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack),
        .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] init_m(int i);  return 16'hA000 + 16'(i); endfunction
    function automatic logic [15:0] init_io(int i); return 16'h5000 + 16'(i); endfunction

    // Memory and I/O model with a one-cycle acknowledge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) begin
                mem_m[i]  <= init_m(i);
                mem_io[i] <= init_io(i);
            end
            bus_ack <= 1'b0;
            bus_gnt <= 1'b0;
        end else begin
            bus_gnt <= bus_req_o;
            bus_ack <= bus_stb_o && !bus_ack;
            if (bus_stb_o && !bus_ack) begin
                if (bus_we_o) begin
                    if (bus_io_o) mem_io[bus_addr_o[9:1]] <= bus_wdata_o;
                    else          mem_m[bus_addr_o[9:1]]  <= bus_wdata_o;
                end else begin
                    bus_rdata <= bus_io_o ? mem_io[bus_addr_o[9:1]] : mem_m[bus_addr_o[9:1]];
                end
            end
        end
    end

    // Monitor: request cycles and the order of source reads.
    always @(negedge clk) begin
        if (bus_req_o) req_cycles = req_cycles + 1;
        if (bus_stb_o && !bus_we_o && bus_ack) begin
            rd_log[rd_total % 64] = bus_addr_o;
            rd_total = rd_total + 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic prog(input logic ch, input logic [19:0] s, input logic [19:0] d, input logic [15:0] n);
        wr({ch, 3'd0}, s[15:0]);
        wr({ch, 3'd1}, {12'd0, s[19:16]});
        wr({ch, 3'd2}, d[15:0]);
        wr({ch, 3'd3}, {12'd0, d[19:16]});
        wr({ch, 3'd4}, n);
    endtask

    // Control word: dio src_io dstep sstep pace prio tmr ie arm
    function automatic logic [15:0] ctl(logic arm, logic ie, logic tm, logic pr, logic [1:0] pace,
                                        logic [1:0] ss, logic [1:0] ds, logic sio, logic dio);
        return {4'd0, dio, sio, ds, ss, pace, pr, tm, ie, arm};
    endfunction

    task automatic wait_cnt(input logic ch, input logic [15:0] target, input string req);
        logic [15:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd({ch, 3'd4}, v);
            if (v == target) break;
        end
        chk(req, 32'(v), 32'(target));
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr = 1'b1;
        @(negedge clk); tmr = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 6; i++) begin
                rd({1'(c), 3'(i)}, v);
                chk("R1 reset register", 32'(v), 32'h0);
            end
        chk("R1 reset irq", 32'(irq_o), 32'h0);
        chk("R1 reset bus_req", 32'(bus_req_o), 32'h0);
    endtask

    task automatic t_free_copy();   // R2 R3 R4 R6 R13
        logic [15:0] v;
        prog(1'b0, 20'h00100, 20'h00200, 16'd4);
        wr(4'h5, ctl(1, 1, 0, 0, 2'b00, 2'b01, 2'b01, 0, 0));
        wait_cnt(1'b0, 16'd0, "R6 free-running reaches zero");
        for (int i = 0; i < 4; i++) chk("R2 copied word", 32'(mem_m[16'h100 + i]), 32'(init_m(16'h80 + i)));
        rd(4'h0, v); chk("R4 source up by 2 per word", 32'(v), 32'h0108);
        rd(4'h2, v); chk("R4 destination up by 2 per word", 32'(v), 32'h0208);
        rd(4'h5, v); chk("R3 arm bit cleared at zero", 32'(v[0]), 32'h0);
        chk("R13 irq raised", 32'(irq_o[0]), 32'h1);
        wr(4'h5, 16'h0);
        @(negedge clk);
        chk("R13 irq cleared by control write", 32'(irq_o[0]), 32'h0);
    endtask

    task automatic t_io_down_hold();   // R4 R5 R13
        logic [15:0] v;
        prog(1'b1, 20'h00040, 20'h00380, 16'd3);
        wr(4'hD, ctl(1, 0, 0, 0, 2'b00, 2'b10, 2'b00, 1, 0));
        wait_cnt(1'b1, 16'd0, "R5 io source run ends");
        chk("R5 io source data, dst held", 32'(mem_m[16'h1C0]), 32'(init_io(16'h1E)));
        rd(4'h8, v); chk("R4 source down by 2 per word", 32'(v), 32'h003A);
        rd(4'hA, v); chk("R4 held destination", 32'(v), 32'h0380);
        chk("R13 no irq without enable", 32'(irq_o[1]), 32'h0);
        wr(4'hD, 16'h0);
    endtask

    task automatic t_wrap();   // R4
        logic [15:0] v;
        prog(1'b0, 20'h00002, 20'h00240, 16'd2);
        wr(4'h5, ctl(1, 0, 0, 0, 2'b00, 2'b10, 2'b01, 0, 0));
        wait_cnt(1'b0, 16'd0, "R4 wrap run ends");
        chk("R4 word read at 0", 32'(mem_m[16'h121]), 32'(init_m(0)));
        rd(4'h0, v); chk("R4 wrapped source low", 32'(v), 32'hFFFE);
        rd(4'h1, v); chk("R4 wrapped source high", 32'(v), 32'h000F);
        wr(4'h5, 16'h0);
    endtask

    task automatic t_zero_count();   // R3
        int base;
        prog(1'b0, 20'h00100, 20'h00200, 16'd0);
        base = req_cycles;
        wr(4'h5, ctl(1, 0, 0, 0, 2'b00, 2'b01, 2'b01, 0, 0));
        repeat (40) @(negedge clk);
        chk("R3 armed with zero count makes no request", 32'(req_cycles - base), 32'h0);
        wr(4'h5, 16'h0);
    endtask

    task automatic t_paced(input logic ch, input logic [1:0] pace, input int hold, input logic [19:0] s,
                           input logic [19:0] d, input string req);
        logic [15:0] v;
        prog(ch, s, d, 16'd5);
        wr({ch, 3'd5}, ctl(1, 0, 0, 0, pace, 2'b01, 2'b01, 0, 0));
        repeat (20) @(negedge clk);
        rd({ch, 3'd4}, v); chk({req, " idle without request"}, 32'(v), 32'd5);
        drq[ch] = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (bus_stb_o && bus_we_o && bus_ack) break;
        end
        repeat (hold) @(negedge clk);
        drq[ch] = 1'b0;
        repeat (30) @(negedge clk);
        rd({ch, 3'd4}, v); chk({req, " one word per request"}, 32'(v), 32'd4);
        chk({req, " paced word copied"}, 32'(mem_m[d[9:1]]), 32'(init_m(32'(s[9:1]))));
        wr({ch, 3'd5}, 16'h0);
    endtask

    task automatic t_timer();   // R9
        logic [15:0] v;
        prog(1'b1, 20'h00140, 20'h002A0, 16'd3);
        drq[1] = 1'b1;
        wr(4'hD, ctl(1, 0, 1, 0, 2'b01, 2'b01, 2'b01, 0, 0));
        repeat (30) @(negedge clk);
        rd(4'hC, v); chk("R9 request line ignored in timer mode", 32'(v), 32'd3);
        pulse_tmr();
        repeat (30) @(negedge clk);
        pulse_tmr();
        repeat (30) @(negedge clk);
        rd(4'hC, v); chk("R9 one word per timer pulse", 32'(v), 32'd1);
        chk("R9 second timer word", 32'(mem_m[16'h151]), 32'(init_m(16'hA1)));
        drq[1] = 1'b0;
        wr(4'hD, 16'h0);
    endtask

    task automatic t_order(input logic p0, input logic p1, input logic [19:0] s0, input logic [19:0] s1,
                           input logic [19:0] d0, input logic [19:0] d1,
                           input logic [19:0] e0, input logic [19:0] e1,
                           input logic [19:0] e2, input logic [19:0] e3, input string req);
        logic [15:0] v;
        int base, lb;
        @(negedge clk); nmi = 1'b1;
        @(negedge clk); nmi = 1'b0;
        prog(1'b0, s0, d0, 16'd2);
        prog(1'b1, s1, d1, 16'd2);
        base = req_cycles;
        wr(4'h5, ctl(1, 0, 0, p0, 2'b00, 2'b01, 2'b01, 0, 0));
        wr(4'hD, ctl(1, 0, 0, p1, 2'b00, 2'b01, 2'b01, 0, 0));
        repeat (30) @(negedge clk);
        chk("R12 no bus request while halted", 32'(req_cycles - base), 32'h0);
        rd(4'h4, v); chk("R12 count kept while halted", 32'(v), 32'd2);
        lb = rd_total;
        @(negedge clk); iret = 1'b1;
        @(negedge clk); iret = 1'b0;
        wait_cnt(1'b0, 16'd0, "R12 released after return");
        wait_cnt(1'b1, 16'd0, "R12 released after return");
        chk({req, " service order 1"}, 32'(rd_log[(lb + 0) % 64]), 32'(e0));
        chk({req, " service order 2"}, 32'(rd_log[(lb + 1) % 64]), 32'(e1));
        chk({req, " service order 3"}, 32'(rd_log[(lb + 2) % 64]), 32'(e2));
        chk({req, " service order 4"}, 32'(rd_log[(lb + 3) % 64]), 32'(e3));
        wr(4'h5, 16'h0);
        wr(4'hD, 16'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_free_copy();
        t_io_down_hold();
        t_wrap();
        t_zero_count();
        t_paced(1'b0, 2'b01, 3, 20'h00120, 20'h00260, "R7 source-paced");
        t_paced(1'b1, 2'b10, 2, 20'h00130, 20'h00270, "R8 destination-paced");
        t_timer();
        t_order(1'b0, 1'b1, 20'h00180, 20'h00160, 20'h002D0, 20'h002C0,
                20'h00160, 20'h00162, 20'h00180, 20'h00182, "R10 priority bit");
        t_order(1'b0, 1'b0, 20'h001A0, 20'h001C0, 20'h002F0, 20'h002E0,
                20'h001C0, 20'h001A0, 20'h001C2, 20'h001A2, "R11 alternation");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule